// File: doc/BRIEF.md
# Timed-Access Register Write Guard

This block sits between the register-write port of a processor core and a small bank of special-function registers. Some of those registers hold settings that must not change by accident. Their guarded bits accept new data only during a short unlock window. Software opens the window by writing an arming value to a key register, then writes an opening value to the same key register. The block holds every register in the bank. Each cycle it presents the stored value of every register, together with the key register and the window count, as plain outputs.

Each guarded register has two constant masks. The first is a timed-access mask. Bits outside it change only during a timed-access write. The second is a writable mask. Bits outside it never change by a write. During reset, three guarded registers load their values from boot-configuration inputs. Four further registers store every write without any guard. The write port is a valid/ready stream. `wr_ready` is held high at all times, so the block never applies back-pressure. A write takes effect on any clock edge where `wr_valid` is high. The register outputs show the new value one cycle after that edge.

Top module: `ta_write_guard`

## Requirements
- R1: A write of 0xAA to the key register (address 0xC7) while the window count is 0 sets the window count to 6 on the next cycle. Every write to 0xC7 stores its data in the key register, and `key_q` shows that data on the next cycle.
- R2: A write of 0xAA to 0xC7 while the window count is nonzero does not reload the count. With `retire` low, the count keeps its value.
- R3: The window count falls by one on each cycle where `retire` is high and the count is nonzero. It stays at 0 when the count is 0. A reload from R1 in the same cycle takes precedence over the decrement.
- R4: A write is a timed access only when the window count is nonzero and `key_q` holds 0x55 in the cycle of the write. Any other write is not a timed access.
- R5: A write to a guarded register stores new data only in the bits set in both its writable mask and its effective timed-access mask. The effective timed-access mask is 0xFF for a timed access and the register's own mask otherwise. All other bits keep their old value. The registers are listed below as address, timed-access mask, writable mask:
  - memory control: 0xC6, 0x0F, 0xF7
  - partition control: 0xD8, 0xEF, 0xFE
  - CRC control: 0xC1, 0xFF, 0x0F
  - power control: 0x87, 0xB9, 0xFF
  - interrupt priority: 0xB8, 0x7F, 0xFF
- R6: Bits outside a guarded register's writable mask never change because of a write, timed or not. Examples are bit 3 of memory control and bit 0 of partition control.
- R7: While `rst_n` is low, the registers load these values:
  - memory control: boot value AND 0xFB;
  - partition control: boot value AND 0x01;
  - CRC control: boot value AND 0xF0;
  - key register, window count and all other registers: 0.
- R8: Writes to CRC low (0xC2), CRC high (0xC3), random number (0xCF) and partition status (0xDA) store the full data byte, whether or not the write is a timed access.
- R9: `wr_ready` is always 1. A cycle without `wr_valid`, or a write to any address not listed above, changes no register. In such a cycle the window count changes only as R3 allows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; loads boot values |
| boot_memctl | input | 8 | Boot value for memory control |
| boot_partctl | input | 8 | Boot value for partition control |
| boot_crcctl | input | 8 | Boot value for CRC control |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Always 1; the write is accepted when `wr_valid` is high |
| wr_addr | input | 8 | Register address of the write |
| wr_data | input | 8 | Data of the write |
| retire | input | 1 | One pulse per retired instruction |
| memctl_q | output | 8 | Memory control register |
| partctl_q | output | 8 | Partition control register |
| crcctl_q | output | 8 | CRC control register |
| pwrctl_q | output | 8 | Power control register |
| intpri_q | output | 8 | Interrupt priority register |
| crclo_q | output | 8 | CRC low byte |
| crchi_q | output | 8 | CRC high byte |
| rng_q | output | 8 | Random number register |
| pstat_q | output | 8 | Partition status register |
| key_q | output | 8 | Key register |
| window_q | output | WIN_W | Unlock window count, WIN_W = $clog2(WIN_LEN+1) |

## Verification
The bench builds the block with its default parameters: a window length of 6, arming value 0xAA and opening value 0x55. With these values the window is short enough that random retire pulses close it often, and random key writes reopen it often. Random streams therefore cover both timed and untimed writes to every guarded register. Directed sequences first reach the corner cases:
- rearming while the window is open;
- a key of 0x55 with the window closed;
- decrementing down to zero;
- reset loading with all-ones boot values.

// File: rtl/tag_pkg.sv
package tag_pkg;
  typedef logic [7:0] byte_t;

  localparam int NGRD = 5;
  localparam int NPLN = 4;

  // guarded registers: memory, partition, crc, power, interrupt priority
  localparam byte_t GRD_ADDR [NGRD] = '{8'hC6, 8'hD8, 8'hC1, 8'h87, 8'hB8};
  localparam byte_t GRD_TA   [NGRD] = '{8'h0F, 8'hEF, 8'hFF, 8'hB9, 8'h7F};
  localparam byte_t GRD_WM   [NGRD] = '{8'hF7, 8'hFE, 8'h0F, 8'hFF, 8'hFF};
  localparam byte_t GRD_RSTM [NGRD] = '{8'hFB, 8'h01, 8'hF0, 8'h00, 8'h00};

  // unguarded registers: crc low, crc high, random number, partition status
  localparam byte_t PLN_ADDR [NPLN] = '{8'hC2, 8'hC3, 8'hCF, 8'hDA};

  function automatic byte_t guard_merge(input byte_t old, input byte_t data,
                                        input byte_t ta, input byte_t wm,
                                        input logic timed);
    byte_t ta_eff;
    byte_t stage;
    ta_eff = timed ? 8'hFF : ta;
    stage  = (old & ~ta_eff) | (data & ta_eff);
    return (old & ~wm) | (stage & wm);
  endfunction
endpackage

// File: rtl/ta_unlock.sv
module ta_unlock #(
  parameter int          WIN_LEN  = 6,
  parameter int          WIN_W    = 3,
  parameter logic [7:0]  KEY_ADDR = 8'hC7,
  parameter logic [7:0]  KEY_ARM  = 8'hAA,
  parameter logic [7:0]  KEY_OPEN = 8'h55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_fire,
  input  logic [7:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             retire,
  output logic [7:0]       key_q,
  output logic [WIN_W-1:0] win_q,
  output logic             timed_o
);
  localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(WIN_LEN);
  localparam logic [WIN_W-1:0] WIN_ONE  = WIN_W'(1);

  logic key_wr;
  logic arm;
  logic win_open;

  assign key_wr   = wr_fire && (wr_addr == KEY_ADDR);
  assign win_open = (win_q != '0);
  assign arm      = key_wr && (wr_data == KEY_ARM) && !win_open;
  assign timed_o  = win_open && (key_q == KEY_OPEN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q <= 8'h00;
      win_q <= '0;
    end else begin
      if (key_wr) key_q <= wr_data;
      if (arm)
        win_q <= WIN_LOAD;
      else if (retire && win_open)
        win_q <= win_q - WIN_ONE;
    end
  end
endmodule

// File: rtl/ta_guard_reg.sv
module ta_guard_reg
  import tag_pkg::*;
#(
  parameter byte_t ADDR     = 8'h00,
  parameter byte_t TA_MASK  = 8'h00,
  parameter byte_t WR_MASK  = 8'hFF,
  parameter byte_t RST_MASK = 8'h00
) (
  input  logic  clk,
  input  logic  rst_n,
  input  byte_t boot,
  input  logic  wr_fire,
  input  byte_t wr_addr,
  input  byte_t wr_data,
  input  logic  timed,
  output byte_t q
);
  logic hit;
  assign hit = wr_fire && (wr_addr == ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n)
      q <= boot & RST_MASK;
    else if (hit)
      q <= guard_merge(q, wr_data, TA_MASK, WR_MASK, timed);
  end
endmodule

// File: rtl/plain_reg.sv
module plain_reg
  import tag_pkg::*;
#(
  parameter byte_t ADDR = 8'h00
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_fire,
  input  byte_t wr_addr,
  input  byte_t wr_data,
  output byte_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      q <= 8'h00;
    else if (wr_fire && (wr_addr == ADDR))
      q <= wr_data;
  end
endmodule

// File: rtl/ta_write_guard.sv
module ta_write_guard
  import tag_pkg::*;
#(
  parameter int          WIN_LEN  = 6,
  parameter logic [7:0]  KEY_ADDR = 8'hC7,
  parameter logic [7:0]  KEY_ARM  = 8'hAA,
  parameter logic [7:0]  KEY_OPEN = 8'h55,
  localparam int         WIN_W    = $clog2(WIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       boot_memctl,
  input  logic [7:0]       boot_partctl,
  input  logic [7:0]       boot_crcctl,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             retire,
  output logic [7:0]       memctl_q,
  output logic [7:0]       partctl_q,
  output logic [7:0]       crcctl_q,
  output logic [7:0]       pwrctl_q,
  output logic [7:0]       intpri_q,
  output logic [7:0]       crclo_q,
  output logic [7:0]       crchi_q,
  output logic [7:0]       rng_q,
  output logic [7:0]       pstat_q,
  output logic [7:0]       key_q,
  output logic [WIN_W-1:0] window_q
);
  logic  wr_fire;
  logic  timed;
  byte_t boot_arr [NGRD];
  byte_t grd_q    [NGRD];
  byte_t pln_q    [NPLN];

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;

  assign boot_arr[0] = boot_memctl;
  assign boot_arr[1] = boot_partctl;
  assign boot_arr[2] = boot_crcctl;
  assign boot_arr[3] = 8'h00;
  assign boot_arr[4] = 8'h00;

  ta_unlock #(
    .WIN_LEN (WIN_LEN),
    .WIN_W   (WIN_W),
    .KEY_ADDR(KEY_ADDR),
    .KEY_ARM (KEY_ARM),
    .KEY_OPEN(KEY_OPEN)
  ) u_unlock (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_fire(wr_fire),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .retire (retire),
    .key_q  (key_q),
    .win_q  (window_q),
    .timed_o(timed)
  );

  for (genvar g = 0; g < NGRD; g++) begin : g_grd
    ta_guard_reg #(
      .ADDR    (GRD_ADDR[g]),
      .TA_MASK (GRD_TA[g]),
      .WR_MASK (GRD_WM[g]),
      .RST_MASK(GRD_RSTM[g])
    ) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .boot   (boot_arr[g]),
      .wr_fire(wr_fire),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .timed  (timed),
      .q      (grd_q[g])
    );
  end

  for (genvar p = 0; p < NPLN; p++) begin : g_pln
    plain_reg #(
      .ADDR(PLN_ADDR[p])
    ) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_fire(wr_fire),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .q      (pln_q[p])
    );
  end

  assign memctl_q  = grd_q[0];
  assign partctl_q = grd_q[1];
  assign crcctl_q  = grd_q[2];
  assign pwrctl_q  = grd_q[3];
  assign intpri_q  = grd_q[4];
  assign crclo_q   = pln_q[0];
  assign crchi_q   = pln_q[1];
  assign rng_q     = pln_q[2];
  assign pstat_q   = pln_q[3];
endmodule

// File: rtl/tag_guard_chk.sv
module tag_guard_chk #(
  parameter int         WIN_LEN  = 6,
  parameter int         WIN_W    = 3,
  parameter logic [7:0] KEY_ADDR = 8'hC7,
  parameter logic [7:0] KEY_ARM  = 8'hAA,
  parameter logic [7:0] KEY_OPEN = 8'h55
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [7:0]       wr_addr,
  input logic [7:0]       wr_data,
  input logic             retire,
  input logic [7:0]       memctl_q,
  input logic [7:0]       partctl_q,
  input logic [7:0]       key_q,
  input logic [WIN_W-1:0] window_q
);
  logic key_wr;
  logic win_nz;
  assign key_wr = wr_valid && (wr_addr == KEY_ADDR);
  assign win_nz = (window_q != '0);

  AST_WIN_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && wr_data == KEY_ARM && !win_nz) |=> (window_q == WIN_W'(WIN_LEN))); // R1

  AST_WIN_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && wr_data == KEY_ARM && win_nz && !retire) |=> $stable(window_q)); // R2

  AST_WIN_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && win_nz) |=> (window_q == $past(window_q) - WIN_W'(1))); // R3

  AST_WIN_STAYS_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_nz && !(key_wr && wr_data == KEY_ARM)) |=> !win_nz); // R3

  AST_UNTIMED_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == 8'hC6 && !(win_nz && key_q == KEY_OPEN))
    |=> ((memctl_q & 8'hF8) == ($past(memctl_q) & 8'hF8))); // R4

  AST_MEM_RO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == 8'hC6) |=> (memctl_q[3] == $past(memctl_q[3]))); // R6

  AST_PART_RO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == 8'hD8) |=> (partctl_q[0] == $past(partctl_q[0]))); // R6

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> ($stable(memctl_q) && $stable(partctl_q) && $stable(key_q))); // R9

  AST_ALWAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_ready); // R9
endmodule

bind ta_write_guard tag_guard_chk #(
  .WIN_LEN (WIN_LEN),
  .WIN_W   (WIN_W),
  .KEY_ADDR(KEY_ADDR),
  .KEY_ARM (KEY_ARM),
  .KEY_OPEN(KEY_OPEN)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .retire   (retire),
  .memctl_q (memctl_q),
  .partctl_q(partctl_q),
  .key_q    (key_q),
  .window_q (window_q)
);

// File: tb/test_ta_write_guard.sv
`timescale 1ns/1ps
module test_ta_write_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] boot_memctl = 8'h00, boot_partctl = 8'h00, boot_crcctl = 8'h00;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_addr = 8'h00, wr_data = 8'h00;
  logic       retire = 1'b0;
  logic [7:0] memctl_q, partctl_q, crcctl_q, pwrctl_q, intpri_q;
  logic [7:0] crclo_q, crchi_q, rng_q, pstat_q, key_q;
  logic [2:0] window_q;

  always #10 clk = ~clk;

  ta_write_guard i_ta_write_guard (
    .clk(clk), .rst_n(rst_n),
    .boot_memctl(boot_memctl), .boot_partctl(boot_partctl), .boot_crcctl(boot_crcctl),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .retire(retire),
    .memctl_q(memctl_q), .partctl_q(partctl_q), .crcctl_q(crcctl_q),
    .pwrctl_q(pwrctl_q), .intpri_q(intpri_q),
    .crclo_q(crclo_q), .crchi_q(crchi_q), .rng_q(rng_q), .pstat_q(pstat_q),
    .key_q(key_q), .window_q(window_q)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model, built from the requirements
  logic [7:0] m_grd [5];
  logic [7:0] m_pln [4];
  logic [7:0] m_key;
  int         m_win;
  localparam logic [7:0] A_GRD [5] = '{8'hC6, 8'hD8, 8'hC1, 8'h87, 8'hB8};
  localparam logic [7:0] M_TA  [5] = '{8'h0F, 8'hEF, 8'hFF, 8'hB9, 8'h7F};
  localparam logic [7:0] M_WR  [5] = '{8'hF7, 8'hFE, 8'h0F, 8'hFF, 8'hFF};
  localparam logic [7:0] A_PLN [4] = '{8'hC2, 8'hC3, 8'hCF, 8'hDA};

  function automatic logic [7:0] exp_merge(logic [7:0] old, logic [7:0] d,
                                           logic [7:0] ta, logic [7:0] wm, bit tmd);
    logic [7:0] upd;
    upd = wm & (tmd ? 8'hFF : ta);
    return (old & ~upd) | (d & upd);
  endfunction

  task automatic chk(string req, string name, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", req, name, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, "/R1"}, "key", key_q, m_key);
    chk({tag, "/R3"}, "window", {5'd0, window_q}, 8'(m_win));
    chk({tag, "/R5"}, "memctl", memctl_q, m_grd[0]);
    chk({tag, "/R5"}, "partctl", partctl_q, m_grd[1]);
    chk({tag, "/R5"}, "crcctl", crcctl_q, m_grd[2]);
    chk({tag, "/R5"}, "pwrctl", pwrctl_q, m_grd[3]);
    chk({tag, "/R5"}, "intpri", intpri_q, m_grd[4]);
    chk({tag, "/R8"}, "crclo", crclo_q, m_pln[0]);
    chk({tag, "/R8"}, "crchi", crchi_q, m_pln[1]);
    chk({tag, "/R8"}, "rng", rng_q, m_pln[2]);
    chk({tag, "/R8"}, "pstat", pstat_q, m_pln[3]);
    chk({tag, "/R9"}, "wr_ready", {7'd0, wr_ready}, 8'h01);
  endtask

  // drive one cycle at the falling edge, advance the model, compare at the next falling edge
  task automatic tick(bit v, logic [7:0] a, logic [7:0] d, bit r, string tag);
    bit tmd;
    wr_valid = v; wr_addr = a; wr_data = d; retire = r;
    tmd = (m_win != 0) && (m_key == 8'h55);
    if (v) begin
      for (int i = 0; i < 5; i++)
        if (a == A_GRD[i]) m_grd[i] = exp_merge(m_grd[i], d, M_TA[i], M_WR[i], tmd);
      for (int i = 0; i < 4; i++)
        if (a == A_PLN[i]) m_pln[i] = d;
    end
    if (v && a == 8'hC7 && d == 8'hAA && m_win == 0) m_win = 6;
    else if (r && m_win != 0) m_win = m_win - 1;
    if (v && a == 8'hC7) m_key = d;
    @(negedge clk);
    wr_valid = 1'b0; retire = 1'b0;
    check_all(tag);
  endtask

  task automatic do_reset(logic [7:0] bm, logic [7:0] bp, logic [7:0] bc);
    rst_n = 1'b0;
    boot_memctl = bm; boot_partctl = bp; boot_crcctl = bc;
    repeat (3) @(negedge clk);
    m_grd[0] = bm & 8'hFB; m_grd[1] = bp & 8'h01; m_grd[2] = bc & 8'hF0;
    m_grd[3] = 8'h00; m_grd[4] = 8'h00;
    for (int i = 0; i < 4; i++) m_pln[i] = 8'h00;
    m_key = 8'h00; m_win = 0;
    check_all("R7");
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240));
    @(negedge clk);
    // R7: boot loading with all ones
    do_reset(8'hFF, 8'hFF, 8'hFF);
    chk("R7", "memctl boot", memctl_q, 8'hFB);
    chk("R7", "partctl boot", partctl_q, 8'h01);
    chk("R7", "crcctl boot", crcctl_q, 8'hF0);
    do_reset(8'h00, 8'h00, 8'h00);

    // R5: untimed write only touches bits 2..0 of memory control
    tick(1, 8'hC6, 8'hFF, 0, "R5 untimed");
    chk("R5", "memctl untimed", memctl_q, 8'h07);
    // R1: arm
    tick(1, 8'hC7, 8'hAA, 0, "R1 arm");
    chk("R1", "window armed", {5'd0, window_q}, 8'd6);
    tick(1, 8'hC7, 8'h55, 0, "R1 open");
    chk("R1", "key stored", key_q, 8'h55);
    // R4/R5/R6: timed write, bit 3 of memory control stays read-only
    tick(1, 8'hC6, 8'hFF, 0, "R4 timed");
    chk("R6", "memctl timed", memctl_q, 8'hF7);
    tick(1, 8'hD8, 8'hFF, 0, "R6 partctl");
    chk("R6", "partctl bit0", partctl_q, 8'hFE);
    // R2: rearm while open does not reload
    tick(1, 8'hC7, 8'hAA, 1, "R2 dec");
    tick(1, 8'hC7, 8'hAA, 0, "R2 rearm");
    chk("R2", "window held", {5'd0, window_q}, 8'd5);
    // R3: count down to zero and hold
    for (int i = 0; i < 6; i++) tick(0, 8'h00, 8'h00, 1, "R3 count");
    chk("R3", "window zero", {5'd0, window_q}, 8'd0);
    // R4: key 0x55 with window shut is not timed
    tick(1, 8'hC7, 8'h55, 0, "R4 key");
    tick(1, 8'hC6, 8'h00, 0, "R4 shut");
    chk("R4", "memctl shut", memctl_q, 8'hF0);
    // R8: unguarded stores
    tick(1, 8'hCF, 8'h3C, 0, "R8 rng");
    chk("R8", "rng", rng_q, 8'h3C);
    // R9: unknown address and idle valid-low with data
    tick(1, 8'h10, 8'hFF, 0, "R9 unknown");
    tick(0, 8'hC6, 8'hAA, 0, "R9 idle");
    chk("R9", "memctl idle", memctl_q, 8'hF0);

    // random phase
    for (int n = 0; n < 6000; n++) begin
      logic [7:0] a, d;
      int sel;
      sel = int'($urandom % 16);
      if (sel < 5) a = 8'hC7;
      else if (sel < 10) a = A_GRD[$urandom % 5];
      else if (sel < 14) a = A_PLN[$urandom % 4];
      else a = 8'($urandom);
      sel = int'($urandom % 5);
      d = (sel < 2) ? 8'hAA : (sel < 4) ? 8'h55 : 8'($urandom);
      tick(($urandom % 4) != 0, a, d, ($urandom % 3) == 0, "rand");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule